// File: doc/BRIEF.md
# Dual-Class Dispatch Queue Pair

This block sits between an allocation stage and the schedulers of an out-of-order core. In each cycle it takes a group of up to three micro-operations, one per input lane. Each micro-operation carries a class tag, a sequence number and a payload. Every valid lane is sent to one of two first-in first-out buffers. Memory work (loads and stores) goes to the memory queue. Everything else goes to the arithmetic queue.

Each queue has its own valid/ready output, and the two outputs drain independently. A stalled memory consumer never holds back arithmetic work, and a stalled arithmetic consumer never holds back memory work. Within one queue, entries leave in the order they were written. Between the two queues there is no ordering. Each class has its own fixed storage, so a burst of one class cannot fill the space meant for the other class.

A group is admitted as a whole or not at all. A synchronous flush empties both queues.

Top module: `dcq_top`

## Requirements
- R1: After reset both output valids are low and `inReady` is high.
- R2: Class code 1 (load) and class code 2 (store) go to the memory queue. Class code 0 (integer) and class code 3 (floating point) go to the arithmetic queue. The class, sequence and payload come out unchanged.
- R3: Up to three lanes can be admitted in one cycle. Only the lanes whose bit in `laneValid` is set are stored. Lane i uses bits [2i+1:2i] of `laneCls`, bits [8i+7:8i] of `laneSeq` and bits [16i+15:16i] of `laneData`.
- R4: When several lanes of one group go to the same queue, the lower lane index is placed ahead of the higher one.
- R5: Each queue is first-in first-out across cycles. While an output is valid and not ready, its head stays unchanged.
- R6: The two queues drain independently. An arithmetic entry can leave while an older memory entry waits, and the reverse also holds.
- R7: Each queue holds eight entries of its own. A full memory queue does not reduce what the arithmetic queue can accept, and a full arithmetic queue does not reduce what the memory queue can accept.
- R8: A group is taken only if each queue has room for all of its lanes of that class. Otherwise `inReady` is low and neither queue stores anything from that group. A queue never holds more than eight entries.
- R9: While `flush` is high, `inReady` is low. On the next cycle both queues are empty, and nothing presented during the flush cycle is stored. Normal operation resumes after the flush.
- R10: A pop in the same cycle frees no room for the group presented in that cycle. A full queue refuses a group bound for it even while its head leaves. A queue with room may push and pop in the same cycle and keeps its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of both queues |
| inValid | input | 1 | An input group is presented |
| laneValid | input | 3 | One bit per lane; set means the lane holds a micro-op |
| laneCls | input | 6 | Class code per lane, 2 bits each |
| laneSeq | input | 24 | Sequence number per lane, 8 bits each |
| laneData | input | 48 | Payload per lane, 16 bits each |
| inReady | output | 1 | The presented group would be admitted |
| memValid | output | 1 | Memory queue head is valid |
| memReady | input | 1 | Memory consumer takes the head |
| memCls | output | 2 | Class code of the memory head |
| memSeq | output | 8 | Sequence number of the memory head |
| memData | output | 16 | Payload of the memory head |
| arValid | output | 1 | Arithmetic queue head is valid |
| arReady | input | 1 | Arithmetic consumer takes the head |
| arCls | output | 2 | Class code of the arithmetic head |
| arSeq | output | 8 | Sequence number of the arithmetic head |
| arData | output | 16 | Payload of the arithmetic head |

## Verification
Two functions can fall in the same cycle: the admission of a group into a queue and the departure of that queue's head. A flush can also coincide with a presented group. The bench holds `arReady` high in the same cycle that it presents a group bound for the arithmetic queue. It does this once with the queue full and once with one free slot. A reference model checks that the full case is refused and that the one-free-slot case keeps the count and the order. For the flush case, a group is presented during flush, and the bench checks that `inReady` is low and that both outputs are empty afterwards.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int LANES  = 3;
  localparam int CLS_W  = 2;
  localparam int QDEPTH = 8;
  localparam int PTR_W  = $clog2(QDEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam int NQ     = 2;
  localparam int QMEM   = 0;
  localparam int QARITH = 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_FP    = 2'd3
  } opClass_t;

  typedef struct packed {
    logic [LANES-1:0]            wrEn;
    logic [LANES-1:0][PTR_W-1:0] wrIdx;
    logic [PTR_W-1:0]            rdIdx;
  } qStrobe_t;

  typedef struct packed {
    qStrobe_t [NQ-1:0] q;
  } dpCtrl_t;

  function automatic logic isMemClass(input logic [CLS_W-1:0] c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction
endpackage

// File: rtl/dcq_ctrl.sv
module dcq_ctrl
  import dcq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        inValid,
  input  logic [LANES-1:0]            laneValid,
  input  logic [LANES*CLS_W-1:0]      laneCls,
  input  logic [NQ-1:0]               outReady,
  output logic [NQ-1:0]               outValid,
  output logic                        inReady,
  output dpCtrl_t                     strobe,
  output logic [NQ-1:0][CNT_W-1:0]    qCount
);
  logic [LANES-1:0][NQ-1:0]            laneSel;
  logic [NQ-1:0][LANES-1:0][PTR_W-1:0] laneOffs;
  logic [NQ-1:0][CNT_W-1:0]            need;
  logic [NQ-1:0]                       room;
  logic [NQ-1:0][PTR_W-1:0]            wrPtr;
  logic [NQ-1:0][PTR_W-1:0]            rdPtr;
  logic [NQ-1:0][CNT_W-1:0]            cnt;
  logic [NQ-1:0][CNT_W-1:0]            pushN;
  logic [NQ-1:0]                       pop;
  logic                                accept;

  // lane steering by class
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneSel[i][QMEM]   = laneValid[i] &  isMemClass(laneCls[i*CLS_W +: CLS_W]);
      laneSel[i][QARITH] = laneValid[i] & ~isMemClass(laneCls[i*CLS_W +: CLS_W]);
    end
  end

  // per-queue compaction offsets and room test
  always_comb begin
    logic [CNT_W-1:0] run;
    for (int q = 0; q < NQ; q++) begin
      run = '0;
      for (int i = 0; i < LANES; i++) begin
        laneOffs[q][i] = run[PTR_W-1:0];
        run = run + CNT_W'(laneSel[i][q]);
      end
      need[q] = run;
      room[q] = ({1'b0, cnt[q]} + {1'b0, run}) <= (CNT_W+1)'(QDEPTH);
    end
  end

  assign inReady = (&room) & ~flush;
  assign accept  = inValid & inReady;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      outValid[q]         = cnt[q] != '0;
      pop[q]              = outValid[q] & outReady[q] & ~flush;
      pushN[q]            = accept ? need[q] : '0;
      strobe.q[q].rdIdx   = rdPtr[q];
      for (int i = 0; i < LANES; i++) begin
        strobe.q[q].wrEn[i]  = accept & laneSel[i][q];
        strobe.q[q].wrIdx[i] = wrPtr[q] + laneOffs[q][i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        wrPtr[q] <= wrPtr[q] + pushN[q][PTR_W-1:0];
        rdPtr[q] <= rdPtr[q] + PTR_W'(pop[q]);
        cnt[q]   <= cnt[q] + pushN[q] - CNT_W'(pop[q]);
      end
    end
  end

  assign qCount = cnt;
endmodule

// File: rtl/dcq_datapath.sv
module dcq_datapath
  import dcq_pkg::*;
#(
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  dpCtrl_t                   strobe,
  input  logic [LANES*CLS_W-1:0]    laneCls,
  input  logic [LANES*SEQ_W-1:0]    laneSeq,
  input  logic [LANES*DATA_W-1:0]   laneData,
  output logic [NQ-1:0][CLS_W-1:0]  outCls,
  output logic [NQ-1:0][SEQ_W-1:0]  outSeq,
  output logic [NQ-1:0][DATA_W-1:0] outData
);
  localparam int ENT_W = CLS_W + SEQ_W + DATA_W;

  logic [LANES-1:0][ENT_W-1:0] laneEnt;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneEnt[i] = {laneCls[i*CLS_W +: CLS_W],
                    laneSeq[i*SEQ_W +: SEQ_W],
                    laneData[i*DATA_W +: DATA_W]};
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [ENT_W-1:0] store [QDEPTH];
    logic [ENT_W-1:0] head;

    always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
        if (strobe.q[q].wrEn[i]) store[strobe.q[q].wrIdx[i]] <= laneEnt[i];
      end
    end

    assign head       = store[strobe.q[q].rdIdx];
    assign outCls[q]  = head[ENT_W-1 -: CLS_W];
    assign outSeq[q]  = head[DATA_W +: SEQ_W];
    assign outData[q] = head[DATA_W-1:0];
  end
endmodule

// File: rtl/dcq_top.sv
module dcq_top
  import dcq_pkg::*;
#(
  parameter int SEQ_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    inValid,
  input  logic [LANES-1:0]        laneValid,
  input  logic [LANES*CLS_W-1:0]  laneCls,
  input  logic [LANES*SEQ_W-1:0]  laneSeq,
  input  logic [LANES*DATA_W-1:0] laneData,
  output logic                    inReady,
  output logic                    memValid,
  input  logic                    memReady,
  output logic [CLS_W-1:0]        memCls,
  output logic [SEQ_W-1:0]        memSeq,
  output logic [DATA_W-1:0]       memData,
  output logic                    arValid,
  input  logic                    arReady,
  output logic [CLS_W-1:0]        arCls,
  output logic [SEQ_W-1:0]        arSeq,
  output logic [DATA_W-1:0]       arData
);
  dpCtrl_t                   strobe;
  logic [NQ-1:0]             outValid;
  logic [NQ-1:0][CNT_W-1:0]  qCount;
  logic [NQ-1:0][CLS_W-1:0]  outCls;
  logic [NQ-1:0][SEQ_W-1:0]  outSeq;
  logic [NQ-1:0][DATA_W-1:0] outData;

  dcq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .inValid  (inValid),
    .laneValid(laneValid),
    .laneCls  (laneCls),
    .outReady ({arReady, memReady}),
    .outValid (outValid),
    .inReady  (inReady),
    .strobe   (strobe),
    .qCount   (qCount)
  );

  dcq_datapath #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .strobe  (strobe),
    .laneCls (laneCls),
    .laneSeq (laneSeq),
    .laneData(laneData),
    .outCls  (outCls),
    .outSeq  (outSeq),
    .outData (outData)
  );

  assign memValid = outValid[QMEM];
  assign memCls   = outCls[QMEM];
  assign memSeq   = outSeq[QMEM];
  assign memData  = outData[QMEM];
  assign arValid  = outValid[QARITH];
  assign arCls    = outCls[QARITH];
  assign arSeq    = outSeq[QARITH];
  assign arData   = outData[QARITH];
endmodule

// File: rtl/dcq_checker.sv
module dcq_checker
  import dcq_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     flush,
  input logic                     inValid,
  input logic                     inReady,
  input logic                     memValid,
  input logic                     memReady,
  input logic [SEQ_W-1:0]         memSeq,
  input logic                     arValid,
  input logic                     arReady,
  input logic [SEQ_W-1:0]         arSeq,
  input logic [NQ-1:0][CNT_W-1:0] qCount
);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!memValid && !arValid));

  a_r9_flush_blocks_input: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !inReady);

  a_r5_mem_head_holds: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && !flush) |=> (memValid && $stable(memSeq)));

  a_r6_ar_head_holds: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady && !flush) |=> (arValid && $stable(arSeq)));

  a_r8_mem_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(qCount[QMEM]) <= QDEPTH);

  a_r8_ar_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(qCount[QARITH]) <= QDEPTH);

  a_r8_refused_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |=> (qCount[QMEM] <= $past(qCount[QMEM]) &&
                               qCount[QARITH] <= $past(qCount[QARITH])));

  a_r3_step_limit: assert property (@(posedge clk) disable iff (!rstN)
    !flush |=> int'(qCount[QMEM]) + int'(qCount[QARITH]) <=
               int'($past(qCount[QMEM])) + int'($past(qCount[QARITH])) + LANES);
endmodule

bind dcq_top dcq_checker #(.SEQ_W(SEQ_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .flush   (flush),
  .inValid (inValid),
  .inReady (inReady),
  .memValid(memValid),
  .memReady(memReady),
  .memSeq  (memSeq),
  .arValid (arValid),
  .arReady (arReady),
  .arSeq   (arSeq),
  .qCount  (qCount)
);

// File: tb/dcq_top_tb_top.sv
`timescale 1ns/1ps
module dcq_top_tb_top;
  localparam int QD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  laneValid = '0;
  logic [5:0]  laneCls = '0;
  logic [23:0] laneSeq = '0;
  logic [47:0] laneData = '0;
  logic        inReady;
  logic        memValid, arValid;
  logic        memReady = 1'b0, arReady = 1'b0;
  logic [1:0]  memCls, arCls;
  logic [7:0]  memSeq, arSeq;
  logic [15:0] memData, arData;

  int total = 0;
  int bad = 0;
  logic [7:0] nextSeq = 8'h10;
  int mq[$];
  int aq[$];

  always #2.5 clk = ~clk;

  dcq_top dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid),
    .laneValid(laneValid), .laneCls(laneCls), .laneSeq(laneSeq), .laneData(laneData),
    .inReady(inReady),
    .memValid(memValid), .memReady(memReady), .memCls(memCls), .memSeq(memSeq), .memData(memData),
    .arValid(arValid), .arReady(arReady), .arCls(arCls), .arSeq(arSeq), .arData(arData)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit isMem(input logic [1:0] c);
    return (c == 2'd1) || (c == 2'd2);
  endfunction

  // present one group; optionally pop arithmetic in the same cycle
  task automatic sendGroup(input logic [2:0] lv, input logic [1:0] c0, input logic [1:0] c1,
                           input logic [1:0] c2, input bit popAr, input string tag);
    logic [1:0] cl[3];
    int nm = 0;
    int na = 0;
    bit exp;
    bit didPop;
    cl[0] = c0; cl[1] = c1; cl[2] = c2;
    for (int i = 0; i < 3; i++) if (lv[i]) begin
      if (isMem(cl[i])) nm++; else na++;
    end
    exp = (mq.size() + nm <= QD) && (aq.size() + na <= QD);
    @(negedge clk);
    laneValid = lv;
    for (int i = 0; i < 3; i++) begin
      logic [7:0] s;
      s = nextSeq + 8'(i);
      laneCls[i*2 +: 2]   = cl[i];
      laneSeq[i*8 +: 8]   = s;
      laneData[i*16 +: 16] = {~s, s};
    end
    inValid = 1'b1;
    arReady = popAr;
    #1;
    chk(tag, "inReady", 32'(inReady), 32'(exp));
    didPop = popAr && (aq.size() != 0);
    if (didPop) chk(tag, "arSeq at same-cycle pop", 32'(arSeq), 32'(aq[0] & 255));
    @(posedge clk);
    #1;
    inValid = 1'b0;
    laneValid = '0;
    arReady = 1'b0;
    if (didPop) void'(aq.pop_front());
    if (exp) begin
      for (int i = 0; i < 3; i++) if (lv[i]) begin
        int e;
        e = (int'(cl[i]) << 8) | int'(8'(nextSeq + 8'(i)));
        if (isMem(cl[i])) mq.push_back(e); else aq.push_back(e);
      end
    end
    nextSeq = nextSeq + 8'd3;
  endtask

  task automatic drainQ(input bit useMem, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int e;
      @(negedge clk);
      if (useMem) begin
        chk(tag, "memValid", 32'(memValid), 32'(mq.size() != 0));
        if (mq.size() != 0) begin
          e = mq[0];
          chk(tag, "memSeq", 32'(memSeq), 32'(e & 255));
          chk(tag, "memCls", 32'(memCls), 32'((e >> 8) & 3));
          chk(tag, "memData", 32'(memData), 32'({~8'(e & 255), 8'(e & 255)}));
        end
        memReady = 1'b1;
        @(posedge clk);
        #1 memReady = 1'b0;
        if (mq.size() != 0) void'(mq.pop_front());
      end else begin
        chk(tag, "arValid", 32'(arValid), 32'(aq.size() != 0));
        if (aq.size() != 0) begin
          e = aq[0];
          chk(tag, "arSeq", 32'(arSeq), 32'(e & 255));
          chk(tag, "arCls", 32'(arCls), 32'((e >> 8) & 3));
          chk(tag, "arData", 32'(arData), 32'({~8'(e & 255), 8'(e & 255)}));
        end
        arReady = 1'b1;
        @(posedge clk);
        #1 arReady = 1'b0;
        if (aq.size() != 0) void'(aq.pop_front());
      end
    end
  endtask

  task automatic checkEmpty(input string tag);
    @(negedge clk);
    chk(tag, "memValid empty", 32'(memValid), 32'd0);
    chk(tag, "arValid empty", 32'(arValid), 32'd0);
    chk(tag, "model empty", 32'(mq.size() + aq.size()), 32'd0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "memValid", 32'(memValid), 32'd0);
    chk("R1", "arValid", 32'(arValid), 32'd0);
    chk("R1", "inReady", 32'(inReady), 32'd1);
  endtask

  task automatic testRouting();
    sendGroup(3'b111, 2'd1, 2'd0, 2'd2, 1'b0, "R2");
    sendGroup(3'b111, 2'd3, 2'd2, 2'd0, 1'b0, "R2");
    drainQ(1'b1, 3, "R2");
    drainQ(1'b0, 3, "R2");
    checkEmpty("R2");
  endtask

  task automatic testLaneOrder();
    sendGroup(3'b111, 2'd0, 2'd3, 2'd0, 1'b0, "R4");
    sendGroup(3'b111, 2'd2, 2'd1, 2'd1, 1'b0, "R4");
    drainQ(1'b0, 3, "R4");
    drainQ(1'b1, 3, "R4");
    checkEmpty("R4");
  endtask

  task automatic testLaneGating();
    sendGroup(3'b101, 2'd0, 2'd1, 2'd3, 1'b0, "R3");
    sendGroup(3'b010, 2'd0, 2'd2, 2'd0, 1'b0, "R3");
    sendGroup(3'b000, 2'd1, 2'd1, 2'd1, 1'b0, "R3");
    drainQ(1'b0, 2, "R3");
    drainQ(1'b1, 1, "R3");
    checkEmpty("R3");
  endtask

  task automatic testFifoAcrossCycles();
    for (int g = 0; g < 4; g++) sendGroup(3'b111, 2'd1, 2'd0, 2'd2, 1'b0, "R5");
    @(negedge clk);
    chk("R5", "head holds seq", 32'(memSeq), 32'(mq[0] & 255));
    drainQ(1'b1, 8, "R5");
    drainQ(1'b0, 4, "R5");
    checkEmpty("R5");
  endtask

  task automatic testIndependent();
    int oldMem;
    sendGroup(3'b111, 2'd1, 2'd0, 2'd0, 1'b0, "R6");
    sendGroup(3'b111, 2'd3, 2'd2, 2'd3, 1'b0, "R6");
    oldMem = mq[0];
    drainQ(1'b0, 4, "R6");
    @(negedge clk);
    chk("R6", "memValid while arith drained", 32'(memValid), 32'd1);
    chk("R6", "oldest mem still at head", 32'(memSeq), 32'(oldMem & 255));
    chk("R6", "arith empty", 32'(arValid), 32'd0);
    drainQ(1'b1, 2, "R6");
    checkEmpty("R6");
  endtask

  task automatic testPartition();
    sendGroup(3'b111, 2'd1, 2'd1, 2'd2, 1'b0, "R7");
    sendGroup(3'b111, 2'd2, 2'd1, 2'd2, 1'b0, "R7");
    sendGroup(3'b011, 2'd1, 2'd1, 2'd0, 1'b0, "R7");
    chk("R7", "mem model full", 32'(mq.size()), 32'(QD));
    sendGroup(3'b111, 2'd0, 2'd3, 2'd0, 1'b0, "R7");
    sendGroup(3'b111, 2'd3, 2'd0, 2'd3, 1'b0, "R7");
    sendGroup(3'b011, 2'd0, 2'd0, 2'd0, 1'b0, "R7");
    chk("R7", "arith model full", 32'(aq.size()), 32'(QD));
    // R8: mixed group refused, nothing stored in either queue
    sendGroup(3'b111, 2'd1, 2'd0, 2'd0, 1'b0, "R8");
    drainQ(1'b0, 2, "R8");
    sendGroup(3'b011, 2'd0, 2'd1, 2'd0, 1'b0, "R8");
    sendGroup(3'b011, 2'd0, 2'd3, 2'd0, 1'b0, "R8");
    drainQ(1'b1, QD, "R8");
    drainQ(1'b0, QD, "R8");
    checkEmpty("R8");
  endtask

  task automatic testPushPop();
    sendGroup(3'b111, 2'd0, 2'd0, 2'd0, 1'b0, "R10");
    sendGroup(3'b111, 2'd0, 2'd3, 2'd0, 1'b0, "R10");
    sendGroup(3'b011, 2'd3, 2'd0, 2'd0, 1'b0, "R10");
    sendGroup(3'b001, 2'd0, 2'd0, 2'd0, 1'b1, "R10");
    chk("R10", "full refused during pop", 32'(aq.size()), 32'(QD - 1));
    sendGroup(3'b001, 2'd3, 2'd0, 2'd0, 1'b1, "R10");
    chk("R10", "count kept", 32'(aq.size()), 32'(QD - 1));
    drainQ(1'b0, QD - 1, "R10");
    checkEmpty("R10");
  endtask

  task automatic testFlush();
    sendGroup(3'b111, 2'd1, 2'd0, 2'd2, 1'b0, "R9");
    sendGroup(3'b111, 2'd3, 2'd2, 2'd0, 1'b0, "R9");
    @(negedge clk);
    flush = 1'b1;
    inValid = 1'b1;
    laneValid = 3'b111;
    laneCls = 6'b01_00_01;
    #1 chk("R9", "inReady during flush", 32'(inReady), 32'd0);
    @(posedge clk);
    #1;
    flush = 1'b0;
    inValid = 1'b0;
    laneValid = '0;
    mq.delete();
    aq.delete();
    checkEmpty("R9");
    @(negedge clk);
    chk("R9", "inReady after flush", 32'(inReady), 32'd1);
    sendGroup(3'b111, 2'd0, 2'd2, 2'd3, 1'b0, "R9");
    drainQ(1'b1, 1, "R9");
    drainQ(1'b0, 2, "R9");
    checkEmpty("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testRouting();
    testLaneOrder();
    testLaneGating();
    testFifoAcrossCycles();
    testIndependent();
    testPartition();
    testPushPop();
    testFlush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule